// File: doc/BRIEF.md
# Host Shared-RAM Address Pointer and Host Interrupt Register

This block sits between an external host and a 1 KB on-chip shared RAM. The host reaches the block through an indexed register window: a register-select input and a 6-bit register index pick which internal register a host write targets. The block keeps the word-aligned address pointer the host uses for RAM data transfers. When the consecutive-access lock is on, the pointer moves by one 32-bit word after every RAM data access, either up or down. The pointer wraps within the 1 KB space. The local CPU can read the pointer but has no way to change it.

The block also keeps an 8-bit interrupt register that both the host and the local CPU can read and write. Bit 0 is the request bit and drives a registered, active-low interrupt pin toward the host. Bits 7 to 1 are scratch storage that software uses to tell the host the cause of the interrupt. They have no effect on any hardware. The RAM array, bus timing and the mode-control register itself are outside the block. The block receives the lock and direction bits as inputs.

Top module: `srhp_top`

## Requirements
- R1: After reset, `ptr_rd` reads 0, `intr_rd` reads 0 and `host_irq_n` is high.
- R2: A host write with `host_rs_n` low and `host_sel` equal to 6'h03 loads the pointer. `ptr_rd` then shows `host_wdata[9:2]` in bits 9 to 2, and bits 31 to 10 and 1 to 0 read 0 whatever value was written.
- R3: A host write with `host_rs_n` high, or with any `host_sel` other than 6'h03, leaves the pointer unchanged.
- R4: A CPU pointer write (`cpu_ptr_wr`) never changes the pointer.
- R5: With `lock_en` high, each `ram_access` pulse changes `ptr_rd` on the next clock edge. It adds 4 when `step_down` is 0 and subtracts 4 when `step_down` is 1.
- R6: Stepping wraps within 1 KB: adding 4 to 0x3FC gives 0x000, and subtracting 4 from 0x000 gives 0x3FC.
- R7: With `lock_en` low, `ram_access` leaves the pointer unchanged.
- R8: A host pointer write in the same cycle as a locked RAM access loads the written value, and no step occurs.
- R9: The interrupt register loads `host_wdata[7:0]` on a host write with `host_rs_n` low and `host_sel` equal to 6'h02. It loads `cpu_wdata[7:0]` on `cpu_intr_wr`. Its value is shown on `intr_rd`.
- R10: When the host and the CPU write the interrupt register in the same cycle, the host value is kept.
- R11: `host_irq_n` is a register that goes low one cycle after interrupt bit 0 becomes 1 and returns high one cycle after it becomes 0. Bits 7 to 1 never affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rs_n | input | 1 | Host register-select, low opens the register window |
| host_sel | input | 6 | Host register index |
| host_wdata | input | 32 | Host write data |
| ram_access | input | 1 | One RAM data access by the host completed this cycle |
| lock_en | input | 1 | Consecutive-access lock mode bit |
| step_down | input | 1 | Step direction, 0 up, 1 down |
| cpu_ptr_wr | input | 1 | CPU write attempt to the pointer (has no effect) |
| cpu_intr_wr | input | 1 | CPU write to the interrupt register |
| cpu_wdata | input | 32 | CPU write data |
| ptr_rd | output | 32 | Pointer read value for both sides |
| intr_rd | output | 8 | Interrupt register read value for both sides |
| host_irq_n | output | 1 | Active-low interrupt pin to the host |

## Verification
The assertions assume that every control input is a clean 0 or 1 at each clock edge and that `ram_access` marks at most one access per cycle. They do not assume any spacing between host and CPU writes. Same-cycle host and CPU writes, and host pointer writes that coincide with locked accesses, are legal and are checked as priority cases. The random stimulus draws every strobe independently, so these collisions occur often. Index values are drawn from the two decoded codes and from undecoded ones, so writes outside the window are also exercised.

// File: rtl/srhp_pkg.sv
package srhp_pkg;
  localparam int unsigned SEL_W  = 6;
  localparam int unsigned INTR_W = 8;

  typedef enum logic { STEP_UP = 1'b0, STEP_DOWN = 1'b1 } step_dir_e;

  localparam logic [SEL_W-1:0] SEL_PTR  = 6'h03;
  localparam logic [SEL_W-1:0] SEL_INTR = 6'h02;
endpackage

// File: rtl/srhp_addr_ptr.sv
module srhp_addr_ptr
  import srhp_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              step_evt,
  input  step_dir_e         step_dir,
  output logic [WORD_W-1:0] word_q
);
  // one-word step; natural width overflow gives the wrap
  function automatic logic [WORD_W-1:0] next_word(input logic [WORD_W-1:0] w,
                                                  input step_dir_e d);
    return (d == STEP_DOWN) ? w - WORD_W'(1) : w + WORD_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        word_q <= '0;
    else if (load)     word_q <= load_word;
    else if (step_evt) word_q <= next_word(word_q, step_dir);
  end

  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> word_q == $past(load_word));
  a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && !load && step_dir == STEP_UP |=> word_q == $past(word_q) + WORD_W'(1));
  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && !load && step_dir == STEP_DOWN |=> word_q == $past(word_q) - WORD_W'(1));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !step_evt |=> $stable(word_q));
endmodule

// File: rtl/srhp_irq_reg.sv
module srhp_irq_reg
  import srhp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [INTR_W-1:0] host_d,
  input  logic              cpu_wr,
  input  logic [INTR_W-1:0] cpu_d,
  output logic [INTR_W-1:0] reg_q,
  output logic              irq_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)       reg_q <= '0;
    else if (host_wr) reg_q <= host_d;
    else if (cpu_wr)  reg_q <= cpu_d;
  end

  // registered, active-low pin following the request bit
  always_ff @(posedge clk) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~reg_q[0];
  end

  a_r10_host_first: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && cpu_wr |=> reg_q == $past(host_d));
  a_r9_cpu_load: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && !host_wr |=> reg_q == $past(cpu_d));
  a_r11_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    reg_q[0] |=> !irq_n);
  a_r11_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_q[0] |=> irq_n);
endmodule

// File: rtl/srhp_top.sv
module srhp_top
  import srhp_pkg::*;
#(
  parameter int unsigned RAM_BYTES = 1024,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rs_n,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              ram_access,
  input  logic              lock_en,
  input  logic              step_down,
  input  logic              cpu_ptr_wr,
  input  logic              cpu_intr_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] ptr_rd,
  output logic [INTR_W-1:0] intr_rd,
  output logic              host_irq_n
);
  localparam int unsigned LSB    = 2;
  localparam int unsigned WORD_W = $clog2(RAM_BYTES) - LSB;
  localparam int unsigned MSB    = LSB + WORD_W - 1;

  // named decode events
  logic              host_ptr_wr, host_intr_wr, step_evt;
  logic [WORD_W-1:0] word_q;

  assign host_ptr_wr  = host_wr && !host_rs_n && (host_sel == SEL_PTR);
  assign host_intr_wr = host_wr && !host_rs_n && (host_sel == SEL_INTR);
  assign step_evt     = ram_access && lock_en;

  srhp_addr_ptr #(.WORD_W(WORD_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (host_ptr_wr),
    .load_word(host_wdata[MSB:LSB]),
    .step_evt (step_evt),
    .step_dir (step_down ? STEP_DOWN : STEP_UP),
    .word_q   (word_q)
  );

  srhp_irq_reg u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .host_wr(host_intr_wr),
    .host_d (host_wdata[INTR_W-1:0]),
    .cpu_wr (cpu_intr_wr),
    .cpu_d  (cpu_wdata[INTR_W-1:0]),
    .reg_q  (intr_rd),
    .irq_n  (host_irq_n)
  );

  assign ptr_rd = DATA_W'({word_q, {LSB{1'b0}}});

  // the CPU has no write path into the pointer
  logic unused_bits;
  assign unused_bits = ^{host_wdata[DATA_W-1:MSB+1], cpu_wdata[DATA_W-1:INTR_W], cpu_ptr_wr};

  a_r4_cpu_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ptr_wr && !host_ptr_wr && !step_evt |=> $stable(ptr_rd));
  a_r3_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && (host_rs_n || host_sel != SEL_PTR) && !step_evt |=> $stable(ptr_rd));
  a_r7_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    ram_access && !lock_en && !host_ptr_wr |=> $stable(ptr_rd));
  a_r9_host_load: assert property (@(posedge clk) disable iff (!rst_n)
    host_intr_wr |=> intr_rd == $past(host_wdata[INTR_W-1:0]));
endmodule

// File: tb/srhp_top_bench.sv
module srhp_top_bench;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rs_n = 1, ram_access = 0, lock_en = 0, step_down = 0;
  logic cpu_ptr_wr = 0, cpu_intr_wr = 0;
  logic [5:0]  host_sel = 0;
  logic [31:0] host_wdata = 0, cpu_wdata = 0;
  logic [31:0] ptr_rd;
  logic [7:0]  intr_rd;
  logic        host_irq_n;

  int tests = 0, fails = 0;
  logic [31:0] e_ptr = 0;
  logic [7:0]  e_intr = 0;
  logic        e_pin = 1;

  always #5 clk = ~clk;

  srhp_top u_srhp_top (.*);

  // byte-address step, computed modulo the RAM size
  function automatic logic [31:0] b_step(input logic [31:0] a, input logic dn);
    int unsigned v = (a + (dn ? 1020 : 4)) % 1024;
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    host_wr = 0; host_rs_n = 1; host_sel = 0; host_wdata = 0; ram_access = 0;
    cpu_ptr_wr = 0; cpu_intr_wr = 0; cpu_wdata = 0;
  endtask

  // apply current inputs for one edge, then compare against the model
  task automatic cyc(input string ptag, input string itag);
    logic [31:0] n_ptr = e_ptr;
    logic [7:0]  n_intr = e_intr;
    logic        n_pin = ~e_intr[0];
    if (host_wr && !host_rs_n && host_sel == 6'h03) n_ptr = host_wdata & 32'h0000_03FC;
    else if (ram_access && lock_en) n_ptr = b_step(e_ptr, step_down);
    if (host_wr && !host_rs_n && host_sel == 6'h02) n_intr = host_wdata[7:0];
    else if (cpu_intr_wr) n_intr = cpu_wdata[7:0];
    @(posedge clk);
    @(negedge clk);
    e_ptr = n_ptr; e_intr = n_intr; e_pin = n_pin;
    check(ptag, ptr_rd, e_ptr);
    check(itag, {24'd0, intr_rd}, {24'd0, e_intr});
    check("R11 pin", {31'd0, host_irq_n}, {31'd0, e_pin});
    idle();
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 ptr", ptr_rd, 0);
    check("R1 intr", {24'd0, intr_rd}, 0);
    check("R1 pin", {31'd0, host_irq_n}, 1);

    // R2: reserved bits read zero
    host_wr = 1; host_rs_n = 0; host_sel = 6'h03; host_wdata = 32'hFFFF_FFFF;
    cyc("R2 load", "R9 idle");
    check("R2 value", ptr_rd, 32'h3FC);
    // R6: wrap up
    lock_en = 1; step_down = 0; ram_access = 1;
    cyc("R6 wrap up", "R9 idle");
    check("R6 value", ptr_rd, 32'h0);
    // R6: wrap down
    lock_en = 1; step_down = 1; ram_access = 1;
    cyc("R6 wrap down", "R9 idle");
    check("R6 value down", ptr_rd, 32'h3FC);
    // R5: plain down step
    lock_en = 1; step_down = 1; ram_access = 1;
    cyc("R5 down", "R9 idle");
    check("R5 value", ptr_rd, 32'h3F8);
    // R7: unlocked access
    lock_en = 0; ram_access = 1;
    cyc("R7 unlocked", "R9 idle");
    // R3: window closed, wrong index
    host_wr = 1; host_rs_n = 1; host_sel = 6'h03; host_wdata = 32'h10;
    cyc("R3 rs high", "R9 idle");
    host_wr = 1; host_rs_n = 0; host_sel = 6'h07; host_wdata = 32'h10;
    cyc("R3 other index", "R9 idle");
    // R4: CPU pointer write
    cpu_ptr_wr = 1; cpu_wdata = 32'h40;
    cyc("R4 cpu write", "R9 idle");
    check("R4 value", ptr_rd, 32'h3F8);
    // R8: write against locked access
    lock_en = 1; ram_access = 1; host_wr = 1; host_rs_n = 0; host_sel = 6'h03;
    host_wdata = 32'h120;
    cyc("R8 collision", "R9 idle");
    check("R8 value", ptr_rd, 32'h120);
    // R10: simultaneous interrupt writes, R11 scratch bits only
    host_wr = 1; host_rs_n = 0; host_sel = 6'h02; host_wdata = 32'hFE;
    cpu_intr_wr = 1; cpu_wdata = 32'h01;
    cyc("R2 hold", "R10 host first");
    cyc("R2 hold", "R11 scratch");
    check("R11 scratch pin", {31'd0, host_irq_n}, 1);
    cpu_intr_wr = 1; cpu_wdata = 32'h81;
    cyc("R2 hold", "R9 cpu");
    cyc("R2 hold", "R11 req");
    check("R11 pin low", {31'd0, host_irq_n}, 0);

    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      int unsigned s = $urandom_range(0, 3);
      host_wr    = $urandom_range(0, 1);
      host_rs_n  = ($urandom_range(0, 3) == 0);
      host_sel   = (s == 0) ? 6'h03 : (s == 1) ? 6'h02 : 6'($urandom_range(0, 63));
      host_wdata = $urandom;
      ram_access = $urandom_range(0, 1);
      lock_en    = ($urandom_range(0, 3) != 0);
      step_down  = $urandom_range(0, 1);
      cpu_ptr_wr = $urandom_range(0, 1);
      cpu_intr_wr = ($urandom_range(0, 2) == 0);
      cpu_wdata  = $urandom;
      cyc("R5 random ptr", "R9 random intr");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule